// File: doc/BRIEF.md
# Descriptor List Walker for a Split DMA

The walker follows a chain of transfer descriptors kept in system memory and turns each one into a transfer command for two separate datapath engines: a read engine that pulls data from the source and a write engine that stores it at the destination. Software builds the chain, points the walker at its head and pulses start. The walker loads each descriptor through a memory read master. It hands the same command to both engines through valid/ready queues. It then waits for a status token from every enabled engine and stores the outcome back into the same descriptor through a memory write master. It then follows the descriptor's link to the next one.

The walk ends at the first descriptor whose hardware-ownership bit is clear. That descriptor is not executed. The walker goes idle and raises a sticky interrupt that software clears with a pulse. Two parameters remove either engine, which gives read-only or write-only variants. Write-back then waits only for the engines that are present.

Descriptor layout: eight 32-bit words at consecutive byte addresses base+4*i.
- Word 0: source address.
- Word 1: destination address.
- Word 2: link to the next descriptor.
- Word 3: byte count.
- Word 4: control.
- Word 5: status.
- Word 6: bytes actually moved.
- Word 7: spare.

Top module: `desc_walker`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o` and loads the descriptor at `head_ptr_i`. The walker reads words 0,1,2,3,4 in that order at byte addresses base, base+4, base+8, base+12 and base+16, with one read outstanding at a time.
- R2: The walker decodes the fetched words as follows.
  - Word 0 is the source address, word 1 the destination address, word 2 the link and word 3 the byte count, each truncated to the port width.
  - Control word 4 holds five flags:
    - bit 0: increment the read address
    - bit 1: increment the write address
    - bit 2: emit start of packet
    - bit 3: emit end of packet
    - bit 31: owned by hardware
- R3: For an owned descriptor, both engine command queues receive the source, destination, byte count and the four flags from R2. Each command valid stays high until that engine's ready is seen.
- R4: An engine's status ready is offered only after that engine has taken its command. Write-back for a descriptor starts only after every enabled engine has returned its status.
- R5: Write-back makes exactly three writes to the current descriptor, in this order:
  - word 6 gets the write engine's byte count, zero-extended
  - word 5 gets the read engine's status code in bits 7:0 and the write engine's status code in bits 15:8, with the other bits zero
  - word 4 gets the fetched control word with bit 31 cleared
- R6: After the three write-back writes, the walker fetches the next descriptor from the address in word 2 of the current one.
- R7: A fetched descriptor with control bit 31 clear ends the walk. It produces no command and no write. `busy_o` drops and `irq_o` rises on the same clock edge.
- R8: `irq_o` stays high until an `irq_clr_i` pulse. A `start_i` pulse while busy is ignored and does not change the walk.
- R9: On both memory masters, a request with no grant is held the next cycle with the same address, and for writes the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk at head_ptr_i (honoured when idle) |
| head_ptr_i | input | ADDR_W | Byte address of the first descriptor |
| irq_clr_i | input | 1 | Clears the sticky interrupt |
| busy_o | output | 1 | Walk in progress |
| irq_o | output | 1 | Sticky end-of-walk interrupt |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | ADDR_W | Descriptor read byte address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 32 | Read data |
| wr_req_o | output | 1 | Write-back request |
| wr_addr_o | output | ADDR_W | Write-back byte address |
| wr_data_o | output | 32 | Write-back data |
| wr_gnt_i | input | 1 | Write request accepted |
| cmd_src_o | output | ADDR_W | Command source address |
| cmd_dst_o | output | ADDR_W | Command destination address |
| cmd_len_o | output | LEN_W | Command byte count |
| cmd_incr_rd_o | output | 1 | Increment read address |
| cmd_incr_wr_o | output | 1 | Increment write address |
| cmd_sop_o | output | 1 | Generate start of packet |
| cmd_eop_o | output | 1 | Generate end of packet |
| rcmd_valid_o | output | 1 | Command valid to read engine |
| rcmd_ready_i | input | 1 | Read engine takes command |
| wcmd_valid_o | output | 1 | Command valid to write engine |
| wcmd_ready_i | input | 1 | Write engine takes command |
| rsts_valid_i | input | 1 | Read engine status valid |
| rsts_ready_o | output | 1 | Read engine status accepted |
| rsts_code_i | input | STS_W | Read engine status code |
| rsts_bytes_i | input | LEN_W | Read engine byte count |
| wsts_valid_i | input | 1 | Write engine status valid |
| wsts_ready_o | output | 1 | Write engine status accepted |
| wsts_code_i | input | STS_W | Write engine status code |
| wsts_bytes_i | input | LEN_W | Bytes actually written |

## Verification
The bench builds the walker with both engines present, a 16-bit address port and a 12-bit byte count.

The descriptor words carry bits above those widths. This makes the truncation of addresses, links and counts visible in every command and every fetch address. A 64-word memory holds eight descriptor slots. Ten runs sweep chain lengths from zero to four owned descriptors, placed at scattered slots.

Across the runs the bench also rotates these conditions:
- grant patterns and ready patterns
- status delays
- the control-flag combinations

Every fetch address, command, write-back word, interrupt edge and ignored restart is checked against values the bench computes from the descriptor contents.

// File: rtl/desc_walker_pkg.sv
package desc_walker_pkg;
  localparam int WORD_W      = 32;
  localparam int FETCH_WORDS = 5;   // words 0..4 are loaded
  localparam int WB_WRITES   = 3;

  localparam int OFS_CTRL = 4;
  localparam int OFS_STS  = 5;
  localparam int OFS_ACT  = 6;

  localparam int CB_INCR_RD = 0;
  localparam int CB_INCR_WR = 1;
  localparam int CB_SOP     = 2;
  localparam int CB_EOP     = 3;
  localparam int CB_OWN     = 31;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] len;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] src;
  } desc_t;
endpackage

// File: rtl/desc_walker_fetch.sv
module desc_walker_fetch
  import desc_walker_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic [ADDR_W-1:0]   base_i,
  output logic                rd_req_o,
  output logic [ADDR_W-1:0]   rd_addr_o,
  input  logic                rd_gnt_i,
  input  logic                rd_rvalid_i,
  input  logic [WORD_W-1:0]   rd_rdata_i,
  output desc_t               desc_o,
  output logic                done_o
);
  localparam int IDX_W = $clog2(FETCH_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FETCH_WORDS - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;

  fst_e              st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  desc_t             desc_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      desc_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (go_i) begin
          base_q <= base_i;
          idx_q  <= '0;
          st_q   <= F_REQ;
        end
        F_REQ: if (rd_gnt_i) st_q <= F_WAIT;
        F_WAIT: if (rd_rvalid_i) begin
          unique case (idx_q)
            3'd0:    desc_q.src  <= rd_rdata_i;
            3'd1:    desc_q.dst  <= rd_rdata_i;
            3'd2:    desc_q.nxt  <= rd_rdata_i;
            3'd3:    desc_q.len  <= rd_rdata_i;
            default: desc_q.ctrl <= rd_rdata_i;
          endcase
          if (idx_q == IDX_LAST) begin
            st_q   <= F_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= F_REQ;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (st_q == F_REQ);
  assign rd_addr_o = base_q + ADDR_W'({idx_q, 2'b00});
  assign desc_o    = desc_q;
  assign done_o    = done_q;

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));
  assert_fetch_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) && (st_q == F_REQ) && (idx_q == '0) |-> rd_addr_o == base_q);
endmodule

// File: rtl/desc_walker_eng.sv
module desc_walker_eng #(
  parameter int LEN_W = 32,
  parameter int STS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  input  logic             sts_valid_i,
  output logic             sts_ready_o,
  input  logic [STS_W-1:0] sts_code_i,
  input  logic [LEN_W-1:0] sts_bytes_i,
  output logic             done_o,
  output logic [STS_W-1:0] code_o,
  output logic [LEN_W-1:0] bytes_o
);
  typedef enum logic [1:0] {E_IDLE, E_CMD, E_STS, E_DONE} est_e;

  est_e             st_q;
  logic [STS_W-1:0] code_q;
  logic [LEN_W-1:0] bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= E_IDLE;
      code_q  <= '0;
      bytes_q <= '0;
    end else begin
      unique case (st_q)
        E_IDLE, E_DONE: if (launch_i) st_q <= E_CMD;
        E_CMD:          if (cmd_ready_i) st_q <= E_STS;
        E_STS: if (sts_valid_i) begin
          code_q  <= sts_code_i;
          bytes_q <= sts_bytes_i;
          st_q    <= E_DONE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (st_q == E_CMD);
  assign sts_ready_o = (st_q == E_STS);
  assign done_o      = (st_q == E_DONE);
  assign code_o      = code_q;
  assign bytes_o     = bytes_q;

  assert_cmd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o);
  assert_sts_after_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_ready_o) |-> $past(cmd_valid_o && cmd_ready_i));
endmodule

// File: rtl/desc_walker_wb.sv
module desc_walker_wb
  import desc_walker_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [WORD_W-1:0] act_i,
  input  logic [WORD_W-1:0] sts_i,
  input  logic [WORD_W-1:0] ctrl_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              wr_gnt_i,
  output logic              done_o
);
  localparam int CNT_W = $clog2(WB_WRITES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WB_WRITES - 1);

  logic              act_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [WORD_W-1:0] act_w_q, sts_w_q, ctrl_w_q;
  logic [2:0]        ofs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      act_w_q  <= '0;
      sts_w_q  <= '0;
      ctrl_w_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !act_q) begin
        act_q    <= 1'b1;
        cnt_q    <= '0;
        base_q   <= base_i;
        act_w_q  <= act_i;
        sts_w_q  <= sts_i;
        ctrl_w_q <= ctrl_i;
      end else if (act_q && wr_gnt_i) begin
        if (cnt_q == CNT_LAST) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // results first, ownership hand-back last
  always_comb begin
    unique case (cnt_q)
      2'd0:    begin ofs = 3'(OFS_ACT);  wr_data_o = act_w_q;  end
      2'd1:    begin ofs = 3'(OFS_STS);  wr_data_o = sts_w_q;  end
      default: begin ofs = 3'(OFS_CTRL); wr_data_o = ctrl_w_q; end
    endcase
  end

  assign wr_req_o  = act_q;
  assign wr_addr_o = base_q + ADDR_W'({ofs, 2'b00});
  assign done_o    = done_q;

  assert_wr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_gnt_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  assert_ctrl_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_addr_o == base_q + ADDR_W'(OFS_CTRL * 4)));
endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import desc_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int STS_W  = 8,
  parameter bit EN_RD  = 1'b1,
  parameter bit EN_WR  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] head_ptr_i,
  input  logic              irq_clr_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_rvalid_i,
  input  logic [31:0]       rd_rdata_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [31:0]       wr_data_o,
  input  logic              wr_gnt_i,
  output logic [ADDR_W-1:0] cmd_src_o,
  output logic [ADDR_W-1:0] cmd_dst_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              cmd_incr_rd_o,
  output logic              cmd_incr_wr_o,
  output logic              cmd_sop_o,
  output logic              cmd_eop_o,
  output logic              rcmd_valid_o,
  input  logic              rcmd_ready_i,
  output logic              wcmd_valid_o,
  input  logic              wcmd_ready_i,
  input  logic              rsts_valid_i,
  output logic              rsts_ready_o,
  input  logic [STS_W-1:0]  rsts_code_i,
  input  logic [LEN_W-1:0]  rsts_bytes_i,
  input  logic              wsts_valid_i,
  output logic              wsts_ready_o,
  input  logic [STS_W-1:0]  wsts_code_i,
  input  logic [LEN_W-1:0]  wsts_bytes_i
);
  localparam int N_ENG = 2;
  localparam logic [N_ENG-1:0] ENG_EN = {EN_WR, EN_RD};

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_WB} st_e;

  st_e               st_q;
  logic              irq_q;
  desc_t             desc;
  logic              f_done, wb_done;
  logic              fetch_go, wb_go, launch, stop, owned;
  logic [ADDR_W-1:0] fetch_base;
  logic [WORD_W-1:0] wb_act, wb_sts, wb_ctrl;

  logic [N_ENG-1:0]  e_cmd_valid, e_cmd_ready, e_sts_valid, e_sts_ready, e_done;
  logic [STS_W-1:0]  e_in_code [N_ENG];
  logic [LEN_W-1:0]  e_in_bytes[N_ENG];
  logic [STS_W-1:0]  e_code    [N_ENG];
  logic [LEN_W-1:0]  e_bytes   [N_ENG];

  assign owned      = desc.ctrl[CB_OWN];
  assign fetch_go   = ((st_q == S_IDLE) && start_i) || ((st_q == S_WB) && wb_done);
  assign fetch_base = (st_q == S_IDLE) ? head_ptr_i : desc.nxt[ADDR_W-1:0];
  assign launch     = (st_q == S_FETCH) && f_done && owned;
  assign stop       = (st_q == S_FETCH) && f_done && !owned;
  assign wb_go      = (st_q == S_RUN) && (&e_done);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      irq_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE:  if (start_i) st_q <= S_FETCH;
        S_FETCH: if (f_done) st_q <= owned ? S_RUN : S_IDLE;
        S_RUN:   if (&e_done) st_q <= S_WB;
        S_WB:    if (wb_done) st_q <= S_FETCH;
        default: st_q <= S_IDLE;
      endcase
      if (stop)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign irq_o  = irq_q;

  desc_walker_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (fetch_go),
    .base_i      (fetch_base),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_gnt_i    (rd_gnt_i),
    .rd_rvalid_i (rd_rvalid_i),
    .rd_rdata_i  (rd_rdata_i),
    .desc_o      (desc),
    .done_o      (f_done)
  );

  // command fields stay stable from launch to the next fetch
  assign cmd_src_o     = desc.src[ADDR_W-1:0];
  assign cmd_dst_o     = desc.dst[ADDR_W-1:0];
  assign cmd_len_o     = desc.len[LEN_W-1:0];
  assign cmd_incr_rd_o = desc.ctrl[CB_INCR_RD];
  assign cmd_incr_wr_o = desc.ctrl[CB_INCR_WR];
  assign cmd_sop_o     = desc.ctrl[CB_SOP];
  assign cmd_eop_o     = desc.ctrl[CB_EOP];

  assign e_cmd_ready   = {wcmd_ready_i, rcmd_ready_i};
  assign e_sts_valid   = {wsts_valid_i, rsts_valid_i};
  assign e_in_code[0]  = rsts_code_i;
  assign e_in_code[1]  = wsts_code_i;
  assign e_in_bytes[0] = rsts_bytes_i;
  assign e_in_bytes[1] = wsts_bytes_i;
  assign rcmd_valid_o  = e_cmd_valid[0];
  assign wcmd_valid_o  = e_cmd_valid[1];
  assign rsts_ready_o  = e_sts_ready[0];
  assign wsts_ready_o  = e_sts_ready[1];

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    if (ENG_EN[g]) begin : g_on
      desc_walker_eng #(.LEN_W(LEN_W), .STS_W(STS_W)) u_eng (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .launch_i    (launch),
        .cmd_valid_o (e_cmd_valid[g]),
        .cmd_ready_i (e_cmd_ready[g]),
        .sts_valid_i (e_sts_valid[g]),
        .sts_ready_o (e_sts_ready[g]),
        .sts_code_i  (e_in_code[g]),
        .sts_bytes_i (e_in_bytes[g]),
        .done_o      (e_done[g]),
        .code_o      (e_code[g]),
        .bytes_o     (e_bytes[g])
      );
    end else begin : g_off
      assign e_cmd_valid[g] = 1'b0;
      assign e_sts_ready[g] = 1'b0;
      assign e_done[g]      = 1'b1;
      assign e_code[g]      = '0;
      assign e_bytes[g]     = '0;
    end
  end

  always_comb begin
    wb_act          = EN_WR ? WORD_W'(e_bytes[1]) : WORD_W'(e_bytes[0]);
    wb_sts          = WORD_W'({e_code[1], e_code[0]});
    wb_ctrl         = desc.ctrl;
    wb_ctrl[CB_OWN] = 1'b0;
  end

  desc_walker_wb #(.ADDR_W(ADDR_W)) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (wb_go),
    .base_i    (u_fetch.base_q),
    .act_i     (wb_act),
    .sts_i     (wb_sts),
    .ctrl_i    (wb_ctrl),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_gnt_i  (wr_gnt_i),
    .done_o    (wb_done)
  );

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rcmd_valid_o && !wcmd_valid_o && !wr_req_o && !rd_req_o);
  assert_irq_at_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(busy_o));
  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);
  assert_masters_apart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req_o && (rcmd_valid_o || wcmd_valid_o || rd_req_o)));
endmodule

// File: tb/desc_walker_tb.sv
module desc_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 12;
  localparam int SW = 8;
  localparam int RUNS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] head = '0;
  logic busy, irq;
  logic rd_req, rd_gnt, rd_rvalid, wr_req, wr_gnt;
  logic [AW-1:0] rd_addr, wr_addr, c_src, c_dst;
  logic [31:0] rd_rdata, wr_data;
  logic [LW-1:0] c_len, rsts_bytes, wsts_bytes;
  logic c_ird, c_iwr, c_sop, c_eop;
  logic rcv, rcr, wcv, wcr, rsv, rsr, wsv, wsr;
  logic [SW-1:0] rsts_code, wsts_code;

  int cyc = 0, mode = 0, errors = 0, checks = 0;
  logic run_clr = 1'b1;
  logic [31:0] mem [64];

  desc_walker #(.ADDR_W(AW), .LEN_W(LW), .STS_W(SW), .EN_RD(1'b1), .EN_WR(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_ptr_i(head), .irq_clr_i(irq_clr),
    .busy_o(busy), .irq_o(irq),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt), .rd_rvalid_i(rd_rvalid),
    .rd_rdata_i(rd_rdata),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_gnt_i(wr_gnt),
    .cmd_src_o(c_src), .cmd_dst_o(c_dst), .cmd_len_o(c_len),
    .cmd_incr_rd_o(c_ird), .cmd_incr_wr_o(c_iwr), .cmd_sop_o(c_sop), .cmd_eop_o(c_eop),
    .rcmd_valid_o(rcv), .rcmd_ready_i(rcr), .wcmd_valid_o(wcv), .wcmd_ready_i(wcr),
    .rsts_valid_i(rsv), .rsts_ready_o(rsr), .rsts_code_i(rsts_code), .rsts_bytes_i(rsts_bytes),
    .wsts_valid_i(wsv), .wsts_ready_o(wsr), .wsts_code_i(wsts_code), .wsts_bytes_i(wsts_bytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit go_ok(int c, int m, int sh);
    return (((c + sh) & (m % 4)) == 0);
  endfunction

  assign rd_gnt = rd_req & go_ok(cyc, mode, 0);
  assign wr_gnt = wr_req & go_ok(cyc, mode, 1);
  assign rcr    = go_ok(cyc, mode, 2);
  assign wcr    = go_ok(cyc, mode + 1, 3);

  // expected descriptor contents
  function automatic int slot(int r, int k); return (k * 3 + r) % 8; endfunction
  function automatic logic [31:0] d_src(int r, int k); return 32'hF000_0000 | 32'(r*4096 + k*64 + 256); endfunction
  function automatic logic [31:0] d_dst(int r, int k); return 32'h0A00_0000 + 32'(r*512 + k*8); endfunction
  function automatic logic [11:0] d_len(int r, int k); return 12'(64 + r*37 + k*101); endfunction
  function automatic logic [3:0]  d_flg(int r, int k); return 4'(r*5 + k*3); endfunction
  function automatic logic [31:0] d_ctrl(int r, int k, bit own);
    return {own, 31'h005A_0000} | 32'(d_flg(r, k));
  endfunction

  // memory and read/write logs
  int rd_n, wr_n, wb_k, bad_r9, bad_r4w;
  logic [AW-1:0] rd_log [32];
  logic [AW-1:0] wa_log [32];
  logic [31:0]   wd_log [32];
  logic p_rreq, p_rgnt, p_wreq, p_wgnt;
  logic [AW-1:0] p_raddr, p_waddr;
  logic [31:0] p_wdata;
  int r_acc, w_acc;

  always @(posedge clk) begin
    if (!rst_n) rd_rvalid <= 1'b0;
    else if (rd_req && rd_gnt) begin
      rd_rvalid <= 1'b1;
      rd_rdata  <= mem[rd_addr[7:2]];
    end else rd_rvalid <= 1'b0;
    if (run_clr) begin
      rd_n <= 0; wr_n <= 0; wb_k <= 0; bad_r9 <= 0; bad_r4w <= 0;
      p_rreq <= 1'b0; p_wreq <= 1'b0;
    end else begin
      if (rd_req && rd_gnt) begin rd_log[rd_n] <= rd_addr; rd_n <= rd_n + 1; end
      if (wr_req && wr_gnt) begin
        mem[wr_addr[7:2]] <= wr_data;
        wa_log[wr_n] <= wr_addr; wd_log[wr_n] <= wr_data; wr_n <= wr_n + 1;
        if (wr_addr[4:2] == 3'd6) begin
          if (r_acc != wb_k + 1 || w_acc != wb_k + 1) bad_r4w <= bad_r4w + 1;
          wb_k <= wb_k + 1;
        end
      end
      if (p_rreq && !p_rgnt && (!rd_req || rd_addr != p_raddr)) bad_r9 <= bad_r9 + 1;
      if (p_wreq && !p_wgnt && (!wr_req || wr_addr != p_waddr || wr_data != p_wdata)) bad_r9 <= bad_r9 + 1;
      p_rreq <= rd_req; p_rgnt <= rd_gnt; p_raddr <= rd_addr;
      p_wreq <= wr_req; p_wgnt <= wr_gnt; p_waddr <= wr_addr; p_wdata <= wr_data;
    end
  end

  // engine models
  int rc_n, wc_n, r_dly, w_dly, bad_r4r, bad_r4x, bad_r3;
  logic r_pend, w_pend;
  logic [LW-1:0] r_len, w_len;
  logic [47:0] rc_log [8];
  logic [47:0] wc_log [8];
  logic p_rcv, p_rcr, p_wcv, p_wcr;

  always @(posedge clk) begin
    if (run_clr) begin
      rc_n <= 0; r_pend <= 1'b0; rsv <= 1'b0; r_acc <= 0; bad_r4r <= 0; bad_r3 <= 0;
      p_rcv <= 1'b0; p_wcv <= 1'b0;
    end else begin
      if (rcv && rcr) begin
        rc_log[rc_n] <= {c_eop, c_sop, c_iwr, c_ird, c_len, c_dst, c_src};
        r_len <= c_len; r_pend <= 1'b1; r_dly <= (rc_n + mode) % 3; rc_n <= rc_n + 1;
      end
      if (r_pend && !rsv) begin
        if (r_dly == 0) begin
          rsv <= 1'b1; rsts_code <= r_len[7:0] ^ 8'hA5; rsts_bytes <= r_len;
        end else r_dly <= r_dly - 1;
      end
      if (rsv && rsr) begin rsv <= 1'b0; r_pend <= 1'b0; r_acc <= r_acc + 1; end
      if (rsr && !r_pend) bad_r4r <= bad_r4r + 1;
      if ((p_rcv && !p_rcr && !rcv) || (p_wcv && !p_wcr && !wcv)) bad_r3 <= bad_r3 + 1;
      p_rcv <= rcv; p_rcr <= rcr; p_wcv <= wcv; p_wcr <= wcr;
    end
  end

  always @(posedge clk) begin
    if (run_clr) begin
      wc_n <= 0; w_pend <= 1'b0; wsv <= 1'b0; w_acc <= 0; bad_r4x <= 0;
    end else begin
      if (wcv && wcr) begin
        wc_log[wc_n] <= {c_eop, c_sop, c_iwr, c_ird, c_len, c_dst, c_src};
        w_len <= c_len; w_pend <= 1'b1; w_dly <= (wc_n + mode + 1) % 4; wc_n <= wc_n + 1;
      end
      if (w_pend && !wsv) begin
        if (w_dly == 0) begin
          wsv <= 1'b1; wsts_code <= w_len[7:0] ^ 8'h3C; wsts_bytes <= w_len - (w_len % 3);
        end else w_dly <= w_dly - 1;
      end
      if (wsv && wsr) begin wsv <= 1'b0; w_pend <= 1'b0; w_acc <= w_acc + 1; end
      if (wsr && !w_pend) bad_r4x <= bad_r4x + 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build(int r, int n);
    for (int i = 0; i < 64; i++) mem[i] = 32'hCAFE_0000 + 32'(i);
    for (int k = 0; k <= n; k++) begin
      int b = slot(r, k) * 8;
      mem[b+0] = d_src(r, k);
      mem[b+1] = d_dst(r, k);
      mem[b+2] = 32'hBEEF_0000 | 32'(slot(r, k + 1) * 32);
      mem[b+3] = 32'hABC0_0000 | 32'(d_len(r, k));
      mem[b+4] = d_ctrl(r, k, k < n);
      mem[b+5] = 32'hDEAD_0000;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R7 reset irq", 64'(irq), 64'd0);
    chk("R9 reset requests", 64'({rd_req, wr_req, rcv, wcv}), 64'd0);
    rst_n = 1'b1;
    for (int r = 0; r < RUNS; r++) begin
      int n = r % 5;
      int t = 0;
      mode = r;
      build(r, n);
      run_clr = 1'b1;
      @(negedge clk);
      run_clr = 1'b0;
      start = 1'b1; head = AW'(slot(r, 0) * 32);
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy after start", 64'(busy), 64'd1);
      @(negedge clk);
      start = 1'b1; head = AW'(slot(r, 7) * 32);   // ignored restart
      @(negedge clk);
      start = 1'b0;
      while (busy && t < 5000) begin @(negedge clk); t++; end
      chk("R7 walk ends", 64'(busy), 64'd0);
      chk("R7 irq raised", 64'(irq), 64'd1);
      chk("R1 R6 R8 fetch count", 64'(rd_n), 64'(5 * (n + 1)));
      for (int i = 0; i < 5 * (n + 1) && i < 32; i++)
        chk("R1 R6 R8 fetch address", 64'(rd_log[i]), 64'(slot(r, i / 5) * 32 + (i % 5) * 4));
      chk("R3 R7 read cmd count", 64'(rc_n), 64'(n));
      chk("R3 R7 write cmd count", 64'(wc_n), 64'(n));
      for (int k = 0; k < n; k++) begin
        logic [47:0] e = {d_flg(r, k), d_len(r, k), d_dst(r, k)[15:0], d_src(r, k)[15:0]};
        chk("R2 R3 read engine command", 64'(rc_log[k]), 64'(e));
        chk("R2 R3 write engine command", 64'(wc_log[k]), 64'(e));
      end
      chk("R5 R7 write count", 64'(wr_n), 64'(3 * n));
      for (int k = 0; k < n; k++) begin
        int b = slot(r, k) * 32;
        logic [11:0] l = d_len(r, k);
        chk("R5 actual bytes addr", 64'(wa_log[3*k]), 64'(b + 24));
        chk("R5 actual bytes data", 64'(wd_log[3*k]), 64'(l - (l % 3)));
        chk("R5 status addr", 64'(wa_log[3*k+1]), 64'(b + 20));
        chk("R5 status data", 64'(wd_log[3*k+1]), 64'({l[7:0] ^ 8'h3C, l[7:0] ^ 8'hA5}));
        chk("R5 control addr", 64'(wa_log[3*k+2]), 64'(b + 16));
        chk("R5 control data", 64'(wd_log[3*k+2]), 64'(d_ctrl(r, k, 1'b0)));
      end
      repeat (4) @(negedge clk);
      chk("R8 irq held", 64'(irq), 64'd1);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R8 irq cleared", 64'(irq), 64'd0);
      chk("R9 request hold", 64'(bad_r9), 64'd0);
      chk("R3 valid hold", 64'(bad_r3), 64'd0);
      chk("R4 status ready after cmd", 64'(bad_r4r + bad_r4x), 64'd0);
      chk("R4 write-back after all status", 64'(bad_r4w), 64'd0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule